// File: doc/BRIEF.md
# 4-bit Substitution Table Cryptographic Profiler

This block grades a 4-bit to 4-bit substitution table against the usual optimality criteria for lightweight ciphers. The table is written one entry at a time through a small load port. A start pulse then launches a sequential sweep. The sweep first checks the table for repeated outputs and for fixed points. It then counts, one input value per clock, every entry of the difference distribution and every entry of the linear approximation table. It keeps the largest of each.

When the sweep completes, the block raises a one-cycle done pulse and presents five results: the worst differential count, the worst linear imbalance, a bijective flag, a fixed-point-free flag, and an overall optimal verdict. These results stay frozen until the next accepted start. A cipher team can use the block to screen candidate tables in silicon or on a prototype before committing one to a datapath.

Top module: `sbox_profiler`

## Requirements
- R1: After reset, `done`, `optimal`, `bijective`, `fixed_free`, `max_diff` and `max_lin` are all zero.
- R2: `max_diff` equals the largest value, over input differences d in 1..15 and output differences e in 0..15, of the number of x in 0..15 with S(x) XOR S(x XOR d) = e.
- R3: `max_lin` equals the largest value, over input masks a in 1..15 and output masks b in 1..15, of |N - 8|. N is the number of x in 0..15 for which the parity of (a AND x) equals the parity of (b AND S(x)).
- R4: `bijective` is 1 exactly when the 16 table entries are all distinct.
- R5: `fixed_free` is 1 exactly when S(x) differs from x for every x.
- R6: `optimal` is 1 exactly when `bijective` and `fixed_free` are 1, `max_diff` is at most 4 and `max_lin` is at most 4.
- R7: `done` is high for exactly one cycle. It rises on the 7457th rising edge after the edge that samples `start` high in idle. That total is 16 scan cycles, plus 3840 differential cycles, plus 3600 linear cycles, plus 1 finish cycle.
- R8: A `start` pulse while a sweep is running is ignored. The sweep is not restarted, and `done` keeps its original timing.
- R9: Between `done` and the next accepted `start`, all five result outputs hold their values.
- R10: A table write while a sweep is running is ignored. The results reflect the table as it was when the sweep was started.
- R11: When idle, a high `tbl_we` on a rising edge stores `tbl_data` as S(`tbl_addr`), so entry i holds the image of input i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index (input value x) |
| tbl_data | input | 4 | Table entry value S(x) |
| start | input | 1 | Launch a profiling sweep (sampled in idle only) |
| done | output | 1 | One-cycle pulse when results are ready |
| max_diff | output | 5 | Worst difference-distribution count (0..16) |
| max_lin | output | 5 | Worst linear imbalance magnitude (0..8) |
| bijective | output | 1 | Table is a permutation |
| fixed_free | output | 1 | Table has no fixed point |
| optimal | output | 1 | Table meets all optimality criteria |

## Verification
Some properties are checked by assertions on every cycle:
- `done` stays single-cycle.
- The differential maximum is always even and never falls during the differential sweep.
- The linear maximum never exceeds 8.
- The results hold steady while idle.
- A start seen mid-run never restarts the scan.

The actual numeric worst-case values, the permutation and fixed-point verdicts, and the exact launch-to-done latency can only be shown by the directed scenarios. These scenarios compare against a table model in the bench for several distinct tables. The same holds for writes and starts issued during a run, which are shown to be ignored by the results they leave behind.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam int NBITS = 4;
    localparam int NENT  = 1 << NBITS;
    localparam int CNTW  = NBITS + 1;
    localparam int HALF  = NENT / 2;
    localparam int DIFF_LIMIT = 4;
    localparam int LIN_LIMIT  = 4;

    typedef logic [NBITS-1:0] word_t;
    typedef logic [CNTW-1:0]  cnt_t;
    typedef logic [NENT-1:0]  mask_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_DIFF,
        PH_LIN,
        PH_FIN
    } phase_e;

    typedef struct packed {
        word_t outer;   // input difference or input mask
        word_t inner;   // output difference or output mask
        word_t x;       // current table input
    } sweep_t;

    localparam word_t WMAX = {NBITS{1'b1}};

    function automatic logic parity(word_t v);
        return ^v;
    endfunction

    function automatic cnt_t imbalance(cnt_t c);
        return (c >= cnt_t'(HALF)) ? (c - cnt_t'(HALF)) : (cnt_t'(HALF) - c);
    endfunction
endpackage

// File: rtl/sbp_table.sv
module sbp_table
    import sbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t waddr,
    input  word_t wdata,
    input  word_t raddr_a,
    input  word_t raddr_b,
    output word_t rdata_a,
    output word_t rdata_b
);
    word_t entry [NENT];

    for (genvar i = 0; i < NENT; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[i] <= '0;
            else if (we && waddr == word_t'(i))
                entry[i] <= wdata;
        end
    end

    assign rdata_a = entry[raddr_a];
    assign rdata_b = entry[raddr_b];
endmodule

// File: rtl/sbp_sweep.sv
module sbp_sweep
    import sbp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    output phase_e phase,
    output sweep_t sw,
    output logic   count_end
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sw    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        phase <= PH_SCAN;
                        sw    <= '0;
                    end
                end
                PH_SCAN: begin
                    sw.x <= sw.x + 1'b1;
                    if (sw.x == WMAX) begin
                        phase    <= PH_DIFF;
                        sw.outer <= word_t'(1);
                        sw.inner <= '0;
                    end
                end
                PH_DIFF: begin
                    sw.x <= sw.x + 1'b1;
                    if (sw.x == WMAX) begin
                        sw.inner <= sw.inner + 1'b1;
                        if (sw.inner == WMAX) begin
                            sw.outer <= sw.outer + 1'b1;
                            if (sw.outer == WMAX) begin
                                phase    <= PH_LIN;
                                sw.outer <= word_t'(1);
                                sw.inner <= word_t'(1);
                            end
                        end
                    end
                end
                PH_LIN: begin
                    sw.x <= sw.x + 1'b1;
                    if (sw.x == WMAX) begin
                        if (sw.inner == WMAX) begin
                            sw.inner <= word_t'(1);
                            sw.outer <= sw.outer + 1'b1;
                            if (sw.outer == WMAX)
                                phase <= PH_FIN;
                        end else begin
                            sw.inner <= sw.inner + 1'b1;
                        end
                    end
                end
                PH_FIN: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign count_end = (phase == PH_DIFF || phase == PH_LIN) && (sw.x == WMAX);
endmodule

// File: rtl/sbp_accum.sv
module sbp_accum
    import sbp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    input  phase_e phase,
    input  sweep_t sw,
    input  logic   count_end,
    input  word_t  s_x,
    input  word_t  s_xd,
    output logic   done,
    output cnt_t   max_diff,
    output cnt_t   max_lin,
    output logic   bijective,
    output logic   fixed_free,
    output logic   optimal
);
    cnt_t  cnt;
    mask_t seen;
    logic  fix_seen;
    logic  hit;
    cnt_t  cnt_final;
    cnt_t  imb;
    mask_t seen_next;
    logic  fix_next;

    always_comb begin
        hit = 1'b0;
        if (phase == PH_DIFF)
            hit = ((s_x ^ s_xd) == sw.inner);
        else if (phase == PH_LIN)
            hit = (parity(sw.outer & sw.x) == parity(sw.inner & s_x));
    end

    assign cnt_final = cnt + cnt_t'(hit);
    assign imb       = imbalance(cnt_final);
    assign seen_next = seen | (mask_t'(1) << s_x);
    assign fix_next  = fix_seen | (s_x == sw.x);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            seen       <= '0;
            fix_seen   <= 1'b0;
            done       <= 1'b0;
            max_diff   <= '0;
            max_lin    <= '0;
            bijective  <= 1'b0;
            fixed_free <= 1'b0;
            optimal    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        cnt        <= '0;
                        seen       <= '0;
                        fix_seen   <= 1'b0;
                        max_diff   <= '0;
                        max_lin    <= '0;
                        bijective  <= 1'b0;
                        fixed_free <= 1'b0;
                        optimal    <= 1'b0;
                    end
                end
                PH_SCAN: begin
                    seen     <= seen_next;
                    fix_seen <= fix_next;
                    if (sw.x == WMAX) begin
                        bijective  <= &seen_next;
                        fixed_free <= ~fix_next;
                    end
                end
                PH_DIFF: begin
                    if (count_end) begin
                        cnt <= '0;
                        if (cnt_final > max_diff)
                            max_diff <= cnt_final;
                    end else begin
                        cnt <= cnt_final;
                    end
                end
                PH_LIN: begin
                    if (count_end) begin
                        cnt <= '0;
                        if (imb > max_lin)
                            max_lin <= imb;
                    end else begin
                        cnt <= cnt_final;
                    end
                end
                PH_FIN: begin
                    done    <= 1'b1;
                    optimal <= bijective && fixed_free &&
                               (max_diff <= cnt_t'(DIFF_LIMIT)) &&
                               (max_lin  <= cnt_t'(LIN_LIMIT));
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DIFF_EVEN: assert property (@(posedge clk) disable iff (rst)
        !max_diff[0]); // R2

    AST_DIFF_MONO: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DIFF && $past(phase) == PH_DIFF) |-> (max_diff >= $past(max_diff))); // R2

    AST_LIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        max_lin <= cnt_t'(HALF)); // R3
endmodule

// File: rtl/sbox_profiler.sv
module sbox_profiler
    import sbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tbl_we,
    input  logic [3:0] tbl_addr,
    input  logic [3:0] tbl_data,
    input  logic       start,
    output logic       done,
    output logic [4:0] max_diff,
    output logic [4:0] max_lin,
    output logic       bijective,
    output logic       fixed_free,
    output logic       optimal
);
    phase_e phase;
    sweep_t sw;
    logic   count_end;
    logic   idle;
    logic   launch;
    logic   we_eff;
    word_t  s_x;
    word_t  s_xd;

    assign idle   = (phase == PH_IDLE);
    assign launch = start && idle;
    assign we_eff = tbl_we && idle;

    sbp_table u_table (
        .clk     (clk),
        .rst     (rst),
        .we      (we_eff),
        .waddr   (tbl_addr),
        .wdata   (tbl_data),
        .raddr_a (sw.x),
        .raddr_b (sw.x ^ sw.outer),
        .rdata_a (s_x),
        .rdata_b (s_xd)
    );

    sbp_sweep u_sweep (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .phase     (phase),
        .sw        (sw),
        .count_end (count_end)
    );

    sbp_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .phase      (phase),
        .sw         (sw),
        .count_end  (count_end),
        .s_x        (s_x),
        .s_xd       (s_xd),
        .done       (done),
        .max_diff   (max_diff),
        .max_lin    (max_lin),
        .bijective  (bijective),
        .fixed_free (fixed_free),
        .optimal    (optimal)
    );

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(idle) && !$past(start)) |->
        ($stable(max_diff) && $stable(max_lin) && $stable(optimal) &&
         $stable(bijective) && $stable(fixed_free))); // R9

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (start && (phase == PH_DIFF || phase == PH_LIN)) |=> (phase != PH_SCAN)); // R8
endmodule

// File: tb/tb_sbox_profiler.sv
`timescale 1ns/1ps
module tb_sbox_profiler;
    localparam int RUN_CYCLES = 16 + 15*16*16 + 15*15*16 + 1;

    logic       clk = 1'b0;
    logic       rst;
    logic       tbl_we;
    logic [3:0] tbl_addr;
    logic [3:0] tbl_data;
    logic       start;
    logic       done;
    logic [4:0] max_diff;
    logic [4:0] max_lin;
    logic       bijective;
    logic       fixed_free;
    logic       optimal;

    int errors = 0;
    int checks = 0;
    logic [3:0] ref_tbl [16];

    always #2 clk = ~clk;

    sbox_profiler dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .start(start), .done(done), .max_diff(max_diff),
        .max_lin(max_lin), .bijective(bijective), .fixed_free(fixed_free),
        .optimal(optimal)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_diff();
        int best = 0;
        for (int d = 1; d < 16; d++)
            for (int e = 0; e < 16; e++) begin
                int n = 0;
                for (int x = 0; x < 16; x++)
                    if ((ref_tbl[x] ^ ref_tbl[x ^ d]) == 4'(e)) n++;
                if (n > best) best = n;
            end
        return best;
    endfunction

    function automatic int model_lin();
        int best = 0;
        for (int a = 1; a < 16; a++)
            for (int b = 1; b < 16; b++) begin
                int n = 0;
                int m;
                for (int x = 0; x < 16; x++)
                    if ((^(4'(a) & 4'(x))) == (^(4'(b) & ref_tbl[x]))) n++;
                m = (n >= 8) ? n - 8 : 8 - n;
                if (m > best) best = m;
            end
        return best;
    endfunction

    function automatic bit model_bij();
        logic [15:0] s = '0;
        for (int x = 0; x < 16; x++) s[ref_tbl[x]] = 1'b1;
        return &s;
    endfunction

    function automatic bit model_ff();
        for (int x = 0; x < 16; x++) if (ref_tbl[x] == 4'(x)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic load(input logic [63:0] packed_tbl);
        for (int i = 0; i < 16; i++) begin
            ref_tbl[i] = packed_tbl[63 - 4*i -: 4];
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 4'(i); tbl_data = ref_tbl[i];
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // launches a run, optionally disturbing it at cycle 100, and checks all results
    task automatic run_and_check(input string name, input bit disturb);
        int n = 0;
        int ed, el;
        bit eb, ef, eo;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (n < RUN_CYCLES + 50) begin
            n++;
            if (disturb && n == 100) begin
                start = 1'b1; tbl_we = 1'b1; tbl_addr = 4'd0; tbl_data = ~ref_tbl[0];
            end else if (disturb && n == 101) begin
                start = 1'b0; tbl_we = 1'b0;
            end
            @(negedge clk);
            if (done) break;
        end
        ed = model_diff(); el = model_lin(); eb = model_bij(); ef = model_ff();
        eo = eb && ef && ed <= 4 && el <= 4;
        $display("table %s: diff=%0d lin=%0d bij=%0d ff=%0d opt=%0d", name,
                 max_diff, max_lin, bijective, fixed_free, optimal);
        chk(n == RUN_CYCLES, disturb ? "R8 done latency with mid-run start" : "R7 done latency",
            n, RUN_CYCLES);
        chk(max_diff == 5'(ed), disturb ? "R10 max_diff after mid-run write" : "R2 max_diff",
            max_diff, ed);
        chk(max_lin == 5'(el), "R3 max_lin", max_lin, el);
        chk(bijective == eb, "R4 bijective", bijective, eb);
        chk(fixed_free == ef, "R5 fixed_free", fixed_free, ef);
        chk(optimal == eo, "R6 optimal", optimal, eo);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(done == 0 && optimal == 0 && bijective == 0 && fixed_free == 0,
            "R1 reset flags", {done, optimal, bijective, fixed_free}, 0);
        chk(max_diff == 0 && max_lin == 0, "R1 reset maxima", {max_diff, max_lin}, 0);
    endtask

    task automatic t_reference();
        load(64'h7EF0DB81934C25A6);
        run_and_check("reference", 1'b0);
        chk(optimal == 1'b1, "R6 reference table optimal", optimal, 1);
    endtask

    task automatic t_hold();
        logic [4:0] d0, l0;
        logic o0;
        d0 = max_diff; l0 = max_lin; o0 = optimal;
        repeat (30) @(negedge clk);
        chk(max_diff == d0 && max_lin == l0 && optimal == o0, "R9 results hold",
            {max_diff, max_lin, optimal}, {d0, l0, o0});
    endtask

    task automatic t_identity();
        load(64'h0123456789ABCDEF);
        run_and_check("identity", 1'b0);
        chk(fixed_free == 1'b0, "R5 identity has fixed points", fixed_free, 0);
    endtask

    task automatic t_constant();
        load(64'h0);
        run_and_check("constant", 1'b0);
        chk(bijective == 1'b0, "R4 constant not bijective", bijective, 0);
    endtask

    task automatic t_affine();
        load(64'h1032547698BADCFE);
        run_and_check("xor-one", 1'b0);
    endtask

    task automatic t_broken();
        load(64'h0EF0DB81934C25A6);
        run_and_check("broken", 1'b0);
    endtask

    task automatic t_disturb();
        load(64'h7EF0DB81934C25A6);
        run_and_check("disturbed", 1'b1);
        chk(optimal == 1'b1, "R10 write during run ignored", optimal, 1);
    endtask

    task automatic t_load_idle();
        // R11: rewriting entry 3 in idle must change the result on the next run
        load(64'h7EF0DB81934C25A6);
        ref_tbl[3] = 4'h3;
        @(negedge clk); tbl_we = 1'b1; tbl_addr = 4'd3; tbl_data = 4'h3;
        @(negedge clk); tbl_we = 1'b0;
        run_and_check("entry3", 1'b0);
        chk(fixed_free == 1'b0, "R11 idle write took effect", fixed_free, 0);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reference();
        t_hold();
        t_identity();
        t_constant();
        t_affine();
        t_broken();
        t_disturb();
        t_load_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule